// File: doc/BRIEF.md
# Block-Merge Scan Pattern Expander

This block turns a compressed serial stream into scan-chain data. Each codeword in the stream describes one block of `BLOCK_BITS` scan bits and how many times in a row that block is applied. The expander reads the codeword one bit at a time, rebuilds the block and shifts it into a single scan chain once per repeat, raising a scan-enable strobe for every bit it emits. While a block is being replayed the expander drops its ready output, so the source holds its next bit until the replay is finished.

A codeword has four parts. The first is a group prefix: `0`, `10`, `110`, `1110` or `1111`. The second is a field of group-number count bits, sent MSB first, which picks the exact repeat count inside the group. The third is a type field: `1` means a mirrored half, `01` means an inverted half and `00` means a full block. The last part is the payload: half a block for the first two types, the whole block for the third. All of this runs in one clock domain. A slower tester appears only through gaps in `in_valid`.

The parser walks through these states, in the order a codeword passes through them. `ST_PREFIX` counts leading ones. A `0`, or a fourth `1`, moves it to `ST_COUNT`, or straight to `ST_TYPE` for group 0. `ST_COUNT` leaves for `ST_TYPE` after the last count bit. From `ST_TYPE`, a `1` goes to `ST_DATA` and a `0` goes to `ST_TYPE2`. `ST_TYPE2` always goes on to `ST_DATA`. `ST_DATA` moves to `ST_EMIT` on the last payload bit. `ST_EMIT` returns to `ST_PREFIX` after the last bit of the last copy.

Top module: `blkmerge_expander`

## Requirements
- R1: After reset `scan_en` is 0 and `in_ready` is 1.
- R2: Group g (prefix of g ones followed by a zero, or four ones for g=4) is followed by g count bits, MSB first, and the repeat count is 2^g plus their value, so groups cover 1, 2–3, 4–7, 8–15 and 16–31 copies; exactly count×BLOCK_BITS bits are emitted per codeword.
- R3: Type `1` carries BLOCK_BITS/2 payload bits; the emitted block is those bits followed by the same bits again in the same order.
- R4: Type `01` carries BLOCK_BITS/2 payload bits; the emitted block is those bits followed by their bitwise inverse in the same order.
- R5: Type `00` carries BLOCK_BITS payload bits, emitted unchanged.
- R6: Block bits leave first-received first; `scan_en` is 1 and carries the first bit in the cycle after the last payload bit is accepted, and stays 1 for all copies without gaps.
- R7: `in_ready` is 0 whenever `scan_en` is 1; bits offered with `in_valid` during that time are ignored and do not change the scan stream.
- R8: A bit is consumed only when `in_valid` and `in_ready` are both 1; idle cycles inside a codeword do not change its result.
- R9: `in_ready` returns to 1 in the cycle right after the last emitted bit, and a new codeword can follow at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for parsing and scan shifting |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compressed bit on `in_bit` is offered |
| in_bit | input | 1 | Compressed stream bit |
| in_ready | output | 1 | Expander can take a stream bit this cycle |
| scan_data | output | 1 | Bit shifted into the scan chain |
| scan_en | output | 1 | Scan shift strobe, high for each emitted bit |

## Verification
The last payload bit is taken at a rising edge. The first scan bit is due one cycle later, and the bench looks for it at the next falling edge. After that, one scan bit is due every cycle for count×BLOCK_BITS cycles, and the bench compares each one, at the falling edge, against a queue it builds from its own encoder. `in_ready` is due high at the first falling edge where `scan_en` has dropped, and that is where the bench checks it. Stall noise and idle gaps are mixed into random and boundary codewords, and the bit-exact stream comparison shows whether they had any effect.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    localparam int GROUPS   = 5;
    localparam int MAX_ONES = GROUPS - 1;
    localparam int RUN_W    = GROUPS;

    typedef enum logic [2:0] {
        ST_PREFIX,
        ST_COUNT,
        ST_TYPE,
        ST_TYPE2,
        ST_DATA,
        ST_EMIT
    } bmx_state_t;

    typedef enum logic [1:0] {
        BT_MIRROR,
        BT_INVERT,
        BT_FULL
    } bmx_kind_t;
endpackage

// File: rtl/bmx_parse_fsm.sv
module bmx_parse_fsm
    import bmx_pkg::*;
#(
    parameter int BLOCK_BITS = 10,
    parameter int IDX_W      = $clog2(BLOCK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             emit_last,
    output logic             in_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             fill_en,
    output logic             fill_inv,
    output logic             start_emit,
    output logic [RUN_W-1:0] run_count
);
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(BLOCK_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(BLOCK_BITS / 2 - 1);
    localparam logic [2:0]       ONES_TOP  = 3'(MAX_ONES - 1);
    localparam logic [2:0]       TOP_GROUP = 3'(MAX_ONES);

    bmx_state_t       state, state_nx;
    bmx_kind_t        kind;
    logic [2:0]       ones_cnt;
    logic [2:0]       cnt_left;
    logic [RUN_W-1:0] run_acc;
    logic [IDX_W-1:0] data_idx;
    logic             take;
    logic             last_data;

    assign take      = in_valid && (state != ST_EMIT);
    assign last_data = (kind == BT_FULL) ? (data_idx == LAST_FULL)
                                         : (data_idx == LAST_HALF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PREFIX;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PREFIX: if (take) begin
                if (!in_bit)
                    state_nx = (ones_cnt == 3'd0) ? ST_TYPE : ST_COUNT;
                else if (ones_cnt == ONES_TOP)
                    state_nx = ST_COUNT;
            end
            ST_COUNT:  if (take && cnt_left == 3'd1) state_nx = ST_TYPE;
            ST_TYPE:   if (take) state_nx = in_bit ? ST_DATA : ST_TYPE2;
            ST_TYPE2:  if (take) state_nx = ST_DATA;
            ST_DATA:   if (take && last_data) state_nx = ST_EMIT;
            ST_EMIT:   if (emit_last) state_nx = ST_PREFIX;
            default:   state_nx = ST_PREFIX;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = (state != ST_EMIT);
        wr_en      = (state == ST_DATA) && take;
        wr_idx     = data_idx;
        start_emit = wr_en && last_data;
        fill_en    = start_emit && (kind != BT_FULL);
        fill_inv   = (kind == BT_INVERT);
        run_count  = run_acc;
    end

    // field registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_cnt <= '0;
            cnt_left <= '0;
            run_acc  <= RUN_W'(1);
            kind     <= BT_FULL;
            data_idx <= '0;
        end else if (take) begin
            unique case (state)
                ST_PREFIX: begin
                    if (!in_bit) begin
                        cnt_left <= ones_cnt;
                        run_acc  <= RUN_W'(1);
                        ones_cnt <= '0;
                    end else if (ones_cnt == ONES_TOP) begin
                        cnt_left <= TOP_GROUP;
                        run_acc  <= RUN_W'(1);
                        ones_cnt <= '0;
                    end else begin
                        ones_cnt <= ones_cnt + 1'b1;
                    end
                end
                ST_COUNT: begin
                    run_acc  <= {run_acc[RUN_W-2:0], in_bit};
                    cnt_left <= cnt_left - 1'b1;
                end
                ST_TYPE: begin
                    if (in_bit) kind <= BT_MIRROR;
                    data_idx <= '0;
                end
                ST_TYPE2: begin
                    kind     <= in_bit ? BT_INVERT : BT_FULL;
                    data_idx <= '0;
                end
                ST_DATA:  data_idx <= data_idx + 1'b1;
                default: ;
            endcase
        end
    end

    AST_PREFIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREFIX) |-> (ones_cnt <= ONES_TOP)); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt_left != 3'd0 && cnt_left <= TOP_GROUP)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && state != ST_EMIT) |=> (state == $past(state))); // R8
endmodule

// File: rtl/bmx_block_asm.sv
module bmx_block_asm #(
    parameter int BLOCK_BITS = 10,
    parameter int IDX_W      = $clog2(BLOCK_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_bit,
    input  logic                  fill_en,
    input  logic                  fill_inv,
    output logic [BLOCK_BITS-1:0] blk_q,
    output logic [BLOCK_BITS-1:0] blk_nx
);
    localparam int HALF = BLOCK_BITS / 2;

    logic [HALF-1:0] hi_nx;
    logic [HALF-1:0] lo_nx;

    // per-position select: hold, incoming bit, or copy/inverse of the upper half
    for (genvar j = 0; j < HALF; j++) begin : g_pos
        always_comb begin
            if (wr_en && wr_idx == IDX_W'(HALF - 1 - j)) hi_nx[j] = wr_bit;
            else                                         hi_nx[j] = blk_q[HALF + j];
        end
        always_comb begin
            if (fill_en)                                       lo_nx[j] = hi_nx[j] ^ fill_inv;
            else if (wr_en && wr_idx == IDX_W'(BLOCK_BITS-1-j)) lo_nx[j] = wr_bit;
            else                                               lo_nx[j] = blk_q[j];
        end
    end

    assign blk_nx = {hi_nx, lo_nx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_nx;
    end

    AST_MIRROR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_inv) |=> (blk_q[BLOCK_BITS-1:HALF] == blk_q[HALF-1:0])); // R3
    AST_INVERT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_inv) |=> (blk_q[BLOCK_BITS-1:HALF] == ~blk_q[HALF-1:0])); // R4
endmodule

// File: rtl/bmx_emit.sv
module bmx_emit #(
    parameter int BLOCK_BITS = 10,
    parameter int IDX_W      = $clog2(BLOCK_BITS),
    parameter int RUN_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RUN_W-1:0]      run_count,
    input  logic [BLOCK_BITS-1:0] load_blk,
    input  logic [BLOCK_BITS-1:0] hold_blk,
    output logic                  scan_data,
    output logic                  scan_en,
    output logic                  emit_last
);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(BLOCK_BITS - 1);
    localparam logic [RUN_W-1:0] ONE_RUN  = RUN_W'(1);

    logic                  busy;
    logic [BLOCK_BITS-1:0] shreg;
    logic [IDX_W-1:0]      bitpos;
    logic [RUN_W-1:0]      runs_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '0;
            bitpos    <= '0;
            runs_left <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            shreg     <= load_blk;
            bitpos    <= '0;
            runs_left <= run_count;
        end else if (busy) begin
            if (bitpos == LAST_POS) begin
                bitpos <= '0;
                if (runs_left == ONE_RUN) begin
                    busy <= 1'b0;
                end else begin
                    runs_left <= runs_left - 1'b1;
                    shreg     <= hold_blk;
                end
            end else begin
                bitpos <= bitpos + 1'b1;
                shreg  <= {shreg[BLOCK_BITS-2:0], 1'b0};
            end
        end
    end

    assign scan_en   = busy;
    assign scan_data = busy & shreg[BLOCK_BITS-1];
    assign emit_last = busy && (bitpos == LAST_POS) && (runs_left == ONE_RUN);

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (runs_left != '0)); // R2
    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bitpos == LAST_POS && runs_left > ONE_RUN)
        |=> (busy && runs_left == $past(runs_left) - 1'b1)); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9
endmodule

// File: rtl/blkmerge_expander.sv
module blkmerge_expander
    import bmx_pkg::*;
#(
    parameter int BLOCK_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic scan_data,
    output logic scan_en
);
    localparam int IDX_W = $clog2(BLOCK_BITS);

    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic                  fill_en;
    logic                  fill_inv;
    logic                  start_emit;
    logic                  emit_last;
    logic [RUN_W-1:0]      run_count;
    logic [BLOCK_BITS-1:0] blk_q;
    logic [BLOCK_BITS-1:0] blk_nx;

    initial begin
        if (BLOCK_BITS < 2 || (BLOCK_BITS % 2) != 0)
            $error("BLOCK_BITS must be even and at least 2");
    end

    bmx_parse_fsm #(.BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .emit_last  (emit_last),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .fill_en    (fill_en),
        .fill_inv   (fill_inv),
        .start_emit (start_emit),
        .run_count  (run_count)
    );

    bmx_block_asm #(.BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_bit   (in_bit),
        .fill_en  (fill_en),
        .fill_inv (fill_inv),
        .blk_q    (blk_q),
        .blk_nx   (blk_nx)
    );

    bmx_emit #(.BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W), .RUN_W(RUN_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_emit),
        .run_count (run_count),
        .load_blk  (blk_nx),
        .hold_blk  (blk_q),
        .scan_data (scan_data),
        .scan_en   (scan_en),
        .emit_last (emit_last)
    );

    AST_STALL_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !in_ready); // R7
    AST_NO_WRITE_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !wr_en); // R7
    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        emit_last |=> in_ready); // R9
endmodule

// File: tb/blkmerge_expander_test.sv
module blkmerge_expander_test;
    localparam int B       = 10;
    localparam int H       = B / 2;
    localparam int CLK_PER = 10;
    localparam int WD_LIM  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, scan_data, scan_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit run_mon = 0;
    bit prev_en = 0;

    bit    exp_q[$];
    string tag_q[$];

    blkmerge_expander #(.BLOCK_BITS(B)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .scan_data(scan_data), .scan_en(scan_en)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: every emitted bit against the bench encoder's queue (R6, R7, R9)
    always @(negedge clk) begin
        if (run_mon) begin
            if (scan_en) begin
                check(!in_ready, "R7", "ready while emitting", int'(in_ready), 0);
                if (exp_q.size() == 0) begin
                    check(0, "R2", "extra scan bit", 1, 0);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(scan_data == e, {t, "/R6"}, "scan bit", int'(scan_data), int'(e));
                end
            end else if (prev_en) begin
                check(in_ready, "R9", "ready after last bit", int'(in_ready), 1);
            end
            prev_en = scan_en;
        end
    end

    // offer one bit; stall noise while not ready (R7), random idle gaps (R8)
    task automatic send_bit(input bit b);
        bit sent = 0;
        while (!sent) begin
            @(negedge clk);
            if (in_ready) begin
                if ($urandom_range(0, 5) == 0) begin
                    in_valid = 1'b0;
                end else begin
                    in_valid = 1'b1;
                    in_bit   = b;
                    sent     = 1;
                end
            end else begin
                in_valid = 1'b1;
                in_bit   = 1'($urandom);
            end
        end
    endtask

    // typ: 0 mirrored half, 1 inverted half, 2 full block
    task automatic send_cw(input int cnt, input int typ, input logic [B-1:0] raw,
                           input string tag);
        int g;
        int n;
        bit q[$];
        logic [B-1:0] blk;
        g = 0;
        while ((cnt >> (g + 1)) != 0) g++;
        for (int i = 0; i < g; i++) q.push_back(1'b1);
        if (g < 4) q.push_back(1'b0);
        for (int i = g - 1; i >= 0; i--) q.push_back(1'((cnt >> i) & 1));
        if (typ == 0) q.push_back(1'b1);
        else begin
            q.push_back(1'b0);
            q.push_back(typ == 1);
        end
        n = (typ == 2) ? B : H;
        for (int i = 0; i < n; i++) q.push_back(raw[B-1-i]);
        if (typ == 0)      blk = {raw[B-1:H], raw[B-1:H]};
        else if (typ == 1) blk = {raw[B-1:H], ~raw[B-1:H]};
        else               blk = raw;
        for (int c = 0; c < cnt; c++)
            for (int i = 0; i < B; i++) begin
                exp_q.push_back(blk[B-1-i]);
                tag_q.push_back(tag);
            end
        foreach (q[k]) send_bit(q[k]);
        @(negedge clk);
        check(scan_en == 1'b1, "R6", "scan_en one cycle after last payload bit",
              int'(scan_en), 1);
        in_valid = 1'b1;
        in_bit   = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(scan_en == 1'b0, "R1", "scan_en in reset", int'(scan_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(scan_en == 1'b0, "R1", "scan_en after reset", int'(scan_en), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        run_mon = 1;

        // R2: group boundary counts
        send_cw(1,  0, 10'b1011000000, "R2");
        send_cw(2,  0, 10'b0110100000, "R2");
        send_cw(3,  2, 10'b1100110101, "R2");
        send_cw(4,  1, 10'b1000100000, "R2");
        send_cw(7,  2, 10'b0000011111, "R2");
        send_cw(8,  0, 10'b0101000000, "R2");
        send_cw(15, 1, 10'b1111100000, "R2");
        send_cw(16, 2, 10'b1010101010, "R2");
        send_cw(31, 0, 10'b0011100000, "R2");
        // R3, R4, R5: per-type corners, all-ones and all-zeros halves
        send_cw(1, 0, 10'b1111100000, "R3");
        send_cw(5, 0, 10'b0000000000, "R3");
        send_cw(1, 1, 10'b0000000000, "R4");
        send_cw(6, 1, 10'b1111111111, "R4");
        send_cw(1, 2, 10'b1000000001, "R5");
        send_cw(9, 2, 10'b0111111110, "R5");
        // random codewords, back to back (R9), with gaps (R8) and noise (R7)
        for (int k = 0; k < 40; k++) begin
            int t;
            t = $urandom_range(0, 2);
            send_cw($urandom_range(1, 31), t, 10'($urandom),
                    (t == 0) ? "R3" : (t == 1) ? "R4" : "R5");
        end

        while (exp_q.size() != 0 && !finished) @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "bits left unemitted", exp_q.size(), 0);
        check(scan_en == 1'b0, "R9", "idle after stream", int'(scan_en), 0);
        check(in_ready == 1'b1, "R9", "ready after stream", int'(in_ready), 1);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WD_LIM) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WD_LIM, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule